// File: doc/BRIEF.md
# Sixteen-Bit Irregular-Operation ALU

This block is the arithmetic and logic unit of a small register machine. It takes three 16-bit operands: a first source, a second source, and the current value of the destination register. A 4-bit operation code picks one of eleven functions. The operation set is unusual. Code 1 is an unsigned greater-than test, not a bitwise AND. Code 2 packs the top nibbles of the two sources together. The shift and rotate codes act on the destination value and take their amount from the second source.

The result is combinational and follows the inputs within the same cycle. The negative, zero and carry flags are registered. Each rising clock edge with a defined operation code loads them from the result of that cycle. An undefined code produces a zero result and leaves the flags as they were. Instruction decode, the register file, memory and sequencing all sit outside this block.

Top module: `alu16_core`

## Requirements
- R1: Code 0 (subtract) gives first source minus second source, modulo 2^16. Its carry is the borrow, set exactly when the first source is below the second as unsigned values.
- R2: Code 1 (greater-than) gives 0x0001 when the first source is above the second as unsigned values, and 0x0000 otherwise.
- R3: Code 2 (nibble pack) gives bits 15:12 of the first source in result bits 7:4 and bits 15:12 of the second source in result bits 3:0. Result bits 15:8 are zero.
- R4: Code 3 (move) passes the first source through unchanged. Code 4 (clear) gives 0x0000.
- R5: Code 5 (increment) gives the destination value plus one, with carry set when that value was 0xFFFF. Code 6 (decrement) gives the destination value minus one, wrapping 0x0000 to 0xFFFF, with carry clear.
- R6: Codes 7 (shift left) and 8 (shift right) shift the destination value logically by the amount in bits 3:0 of the second source. Zeros fill the vacated bits. Carry is the last bit shifted out, and is 0 for an amount of 0.
- R7: Codes 9 (rotate left) and 10 (rotate right) rotate the destination value by bits 3:0 of the second source. An amount of 0 returns the value unchanged. Carry is clear.
- R8: At each rising clock edge with a code from 0 to 10, the flags load from that cycle's result: N takes result bit 15, Z is set when the result is zero, and C is as defined per operation. C is 0 for codes 1, 2, 3, 4, 9 and 10.
- R9: Codes 11 to 15 give a result of 0x0000 and leave all three flags unchanged across the clock edge.
- R10: While the active-low reset is low, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_sel | input | 4 | Operation code |
| src_a | input | 16 | First source operand |
| src_b | input | 16 | Second source operand; bits 3:0 are the shift or rotate amount |
| dst_val | input | 16 | Current destination register value |
| result | output | 16 | Combinational result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry/borrow flag |

## Verification
The hardest behaviour to observe is the flag hold for undefined codes. Flags that are already zero look the same whether they held or were cleared, so a test from that state cannot tell the difference. The stimulus therefore first runs a subtract that leaves N and C set and Z clear. It then steps through every undefined code and checks after each edge that this nonzero pattern is still there. The shift carry at the extreme amounts of 0, 1 and 15 is also hard to reach from the ports. The vector table includes operands whose last outgoing bit is a one at each of these amounts, plus a second source whose upper bits are nonzero but whose low nibble is 0.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OP_SUB = 4'd0,
      OP_GT  = 4'd1,
      OP_CAT = 4'd2,
      OP_MOV = 4'd3,
      OP_CLR = 4'd4,
      OP_INC = 4'd5,
      OP_DEC = 4'd6,
      OP_SHL = 4'd7,
      OP_SHR = 4'd8,
      OP_ROL = 4'd9,
      OP_ROR = 4'd10
   } alu_op_e;

   localparam int unsigned OP_W    = 4;
   localparam int unsigned OP_LAST = 10;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] dst,
   output logic [DATA_W-1:0] diff,
   output logic              borrow,
   output logic              a_above_b,
   output logic [DATA_W-1:0] incr,
   output logic              incr_cy,
   output logic [DATA_W-1:0] decr
);

   localparam logic [DATA_W:0] ONE_EXT = {{DATA_W{1'b0}}, 1'b1};

   logic [DATA_W:0] sub_ext;
   logic [DATA_W:0] inc_ext;

   always_comb begin
      sub_ext   = {1'b0, opa} - {1'b0, opb};
      diff      = sub_ext[DATA_W-1:0];
      borrow    = sub_ext[DATA_W];
      a_above_b = (opa > opb);
      inc_ext   = {1'b0, dst} + ONE_EXT;
      incr      = inc_ext[DATA_W-1:0];
      incr_cy   = inc_ext[DATA_W];
      decr      = dst - ONE_EXT[DATA_W-1:0];
   end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int unsigned DATA_W       = 16,
   parameter bit          BARREL_SHIFT = 1'b1,
   localparam int unsigned AMT_W       = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] dst,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] shl_res,
   output logic              shl_cy,
   output logic [DATA_W-1:0] shr_res,
   output logic              shr_cy,
   output logic [DATA_W-1:0] rol_res,
   output logic [DATA_W-1:0] ror_res
);

   if ((1 << AMT_W) != DATA_W) begin : g_bad_width
      $error("alu16_shift: DATA_W must be a power of two");
   end

   if (BARREL_SHIFT) begin : g_barrel
      logic [DATA_W:0]   lst [AMT_W+1];
      logic [DATA_W:0]   rst [AMT_W+1];
      logic [DATA_W-1:0] lro [AMT_W+1];
      logic [DATA_W-1:0] rro [AMT_W+1];

      assign lst[0] = {1'b0, dst};
      assign rst[0] = {dst, 1'b0};
      assign lro[0] = dst;
      assign rro[0] = dst;

      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int unsigned SH = 1 << s;
         assign lst[s+1] = amt[s] ? (lst[s] << SH) : lst[s];
         assign rst[s+1] = amt[s] ? (rst[s] >> SH) : rst[s];
         assign lro[s+1] = amt[s] ? {lro[s][DATA_W-1-SH:0], lro[s][DATA_W-1:DATA_W-SH]}
                                  : lro[s];
         assign rro[s+1] = amt[s] ? {rro[s][SH-1:0], rro[s][DATA_W-1:SH]}
                                  : rro[s];
      end

      assign shl_res = lst[AMT_W][DATA_W-1:0];
      assign shl_cy  = lst[AMT_W][DATA_W];
      assign shr_res = rst[AMT_W][DATA_W:1];
      assign shr_cy  = rst[AMT_W][0];
      assign rol_res = lro[AMT_W];
      assign ror_res = rro[AMT_W];
   end else begin : g_operator
      logic [DATA_W:0]     l_ext;
      logic [DATA_W:0]     r_ext;
      logic [2*DATA_W-1:0] l_dbl;
      logic [2*DATA_W-1:0] r_dbl;

      always_comb begin
         l_ext   = {1'b0, dst} << amt;
         r_ext   = {dst, 1'b0} >> amt;
         l_dbl   = {dst, dst} << amt;
         r_dbl   = {dst, dst} >> amt;
         shl_res = l_ext[DATA_W-1:0];
         shl_cy  = l_ext[DATA_W];
         shr_res = r_ext[DATA_W:1];
         shr_cy  = r_ext[0];
         rol_res = l_dbl[2*DATA_W-1:DATA_W];
         ror_res = r_dbl[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] res,
   input  logic              cy_in,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_c <= 1'b0;
      end else if (upd_en) begin
         flag_n <= res[DATA_W-1];
         flag_z <= (res == '0);
         flag_c <= cy_in;
      end
   end

   // R9: flags hold across an edge without an update
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable({flag_n, flag_z, flag_c}));

   // R8: negative and zero flags are never both set
   p_nz_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_n && flag_z));

endmodule

// File: rtl/alu16_core.sv
module alu16_core
   import alu16_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned NIB_W        = 4,
   parameter bit          BARREL_SHIFT = 1'b1,
   localparam int unsigned AMT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] dst_val,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c
);

   localparam int unsigned PACK_W = 2 * NIB_W;

   if (PACK_W > DATA_W) begin : g_bad_nib
      $error("alu16_core: two nibbles must fit in DATA_W");
   end

   logic [DATA_W-1:0] diff, incr, decr;
   logic              borrow, a_above_b, incr_cy;
   logic [DATA_W-1:0] shl_res, shr_res, rol_res, ror_res;
   logic              shl_cy, shr_cy;
   logic [PACK_W-1:0] packed_nib;
   logic              cy_sel;
   logic              op_valid;

   alu16_arith #(.DATA_W(DATA_W)) u_arith (
      .opa       (src_a),
      .opb       (src_b),
      .dst       (dst_val),
      .diff      (diff),
      .borrow    (borrow),
      .a_above_b (a_above_b),
      .incr      (incr),
      .incr_cy   (incr_cy),
      .decr      (decr)
   );

   alu16_shift #(.DATA_W(DATA_W), .BARREL_SHIFT(BARREL_SHIFT)) u_shift (
      .dst     (dst_val),
      .amt     (src_b[AMT_W-1:0]),
      .shl_res (shl_res),
      .shl_cy  (shl_cy),
      .shr_res (shr_res),
      .shr_cy  (shr_cy),
      .rol_res (rol_res),
      .ror_res (ror_res)
   );

   assign packed_nib = {src_a[DATA_W-1 -: NIB_W], src_b[DATA_W-1 -: NIB_W]};

   always_comb begin
      result   = '0;
      cy_sel   = 1'b0;
      op_valid = 1'b1;
      case (op_sel)
         OP_SUB: begin result = diff;    cy_sel = borrow;  end
         OP_GT:  result = {{(DATA_W-1){1'b0}}, a_above_b};
         OP_CAT: result = {{(DATA_W-PACK_W){1'b0}}, packed_nib};
         OP_MOV: result = src_a;
         OP_CLR: result = '0;
         OP_INC: begin result = incr;    cy_sel = incr_cy; end
         OP_DEC: result = decr;
         OP_SHL: begin result = shl_res; cy_sel = shl_cy;  end
         OP_SHR: begin result = shr_res; cy_sel = shr_cy;  end
         OP_ROL: result = rol_res;
         OP_ROR: result = ror_res;
         default: op_valid = 1'b0;
      endcase
   end

   alu16_flags #(.DATA_W(DATA_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (op_valid),
      .res    (result),
      .cy_in  (cy_sel),
      .flag_n (flag_n),
      .flag_z (flag_z),
      .flag_c (flag_c)
   );

   // R2: greater-than yields a single-bit value
   p_gt_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_GT) |-> (result[DATA_W-1:1] == '0));

   // R3: packed nibbles leave the upper byte clear
   p_cat_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_CAT) |-> (result[DATA_W-1:PACK_W] == '0));

   // R4: move reproduces the first source
   p_mov_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_MOV) |-> (result == src_a));

   // R7: rotate by zero is identity
   p_rot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_sel == OP_ROL || op_sel == OP_ROR) && src_b[AMT_W-1:0] == '0)
         |-> (result == dst_val));

   // R8: zero flag follows previous defined result
   p_z_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel <= OP_LAST) |=> (flag_z == ($past(result) == '0)));

   // R9: undefined codes give zero
   p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > OP_LAST) |-> (result == '0));

endmodule

// File: tb/test_alu16_core.sv
module test_alu16_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = 4'd0;
   logic [15:0] src_a = '0, src_b = '0, dst_val = '0;
   logic [15:0] result;
   logic        flag_n, flag_z, flag_c;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   alu16_core i_alu16_core (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
      .dst_val(dst_val), .result(result), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c)
   );

   localparam int NV = 19;
   // Fields: op, src_a, src_b, dst_val, expected result, expected carry, requirement
   localparam logic [3:0]  V_OP [NV] = '{4'd0, 4'd0, 4'd1, 4'd1, 4'd2, 4'd3, 4'd4,
      4'd5, 4'd5, 4'd6, 4'd7, 4'd7, 4'd7, 4'd8, 4'd8, 4'd9, 4'd10, 4'd9, 4'd10};
   localparam logic [15:0] V_A [NV] = '{16'h0005, 16'h0003, 16'h8000, 16'h1234,
      16'hABCD, 16'h8001, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
      16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
   localparam logic [15:0] V_B [NV] = '{16'h0003, 16'h0005, 16'h7FFF, 16'h1234,
      16'h1234, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0001, 16'h0005, 16'h000F,
      16'h0001, 16'h00F0, 16'h0004, 16'h0001, 16'h0010, 16'h0004};
   localparam logic [15:0] V_D [NV] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
      16'h0, 16'hFFFF, 16'h0041, 16'h0000, 16'h8001, 16'h0F00, 16'h0003, 16'h0003,
      16'h8000, 16'h8001, 16'h0001, 16'h1234, 16'h1234};
   localparam logic [15:0] V_R [NV] = '{16'h0002, 16'hFFFE, 16'h0001, 16'h0000,
      16'h00A1, 16'h8001, 16'h0000, 16'h0000, 16'h0042, 16'hFFFF, 16'h0002,
      16'hE000, 16'h8000, 16'h0001, 16'h8000, 16'h0018, 16'h8000, 16'h1234,
      16'h4123};
   localparam logic        V_C [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam string       V_Q [NV] = '{"R1", "R1", "R2", "R2", "R3", "R4", "R4",
      "R5", "R5", "R5", "R6", "R6", "R6", "R6", "R6", "R7", "R7", "R7", "R7"};

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R10: flags clear under reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", {29'd0, flag_n, flag_z, flag_c}, 32'd0);
      rst_n = 1'b1;

      // Vector table: R1..R7 results, R8 flags
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_sel = V_OP[i]; src_a = V_A[i]; src_b = V_B[i]; dst_val = V_D[i];
         #2;
         check(V_Q[i], {16'd0, result}, {16'd0, V_R[i]});
         @(posedge clk);
         #2;
         check("R8", {29'd0, flag_n, flag_z, flag_c},
               {29'd0, V_R[i][15], (V_R[i] == 16'h0), V_C[i]});
      end

      // R9: load a nonzero flag pattern, then every undefined code must keep it
      @(negedge clk);
      op_sel = 4'd0; src_a = 16'h0003; src_b = 16'h0005; dst_val = 16'h0;
      @(posedge clk);
      #2;
      check("R8", {29'd0, flag_n, flag_z, flag_c}, {29'd0, 3'b101});
      for (int c = 11; c < 16; c++) begin
         @(negedge clk);
         op_sel = 4'(c); src_a = 16'hFFFF; src_b = 16'hFFFF; dst_val = 16'hFFFF;
         #2;
         check("R9", {16'd0, result}, 32'd0);
         @(posedge clk);
         #2;
         check("R9", {29'd0, flag_n, flag_z, flag_c}, {29'd0, 3'b101});
      end

      // R8: a zero result sets Z and clears N and C
      @(negedge clk);
      op_sel = 4'd4;
      @(posedge clk);
      #2;
      check("R8", {29'd0, flag_n, flag_z, flag_c}, {29'd0, 3'b010});

      // R10: reset in the middle of a run clears the flags
      @(negedge clk);
      op_sel = 4'd0; src_a = 16'h0001; src_b = 16'h0002;
      @(posedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      check("R10", {29'd0, flag_n, flag_z, flag_c}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      finish_run();
   end

endmodule